// File: doc/BRIEF.md
# Trap CSR File with Exception-PC Legalization

This block holds the trap-handling control and status registers of a 64-bit hart at machine and supervisor level: scratch, exception PC, cause and trap value for each level. It also holds the ISA description register and the machine status register, because the rest of its outputs depend on them. A single write port takes a 12-bit CSR address, write data and a write enable, and the write lands on the next rising clock edge. Read data is combinational from the address.

Writes to either exception-PC register are legalized so that the stored value is always a valid instruction address. When compressed instructions are enabled, bit 0 is forced low. When they are disabled, bits 1:0 are forced low. The block also reports the effective architecture width code for the current privilege, a flag for 32-bit operation, and presence flags for the atomic, compressed, multiply/divide and floating-point extensions. If the selected width field holds the invalid code, a sticky error output is raised.

Top module: `trap_csr_file`

## Requirements
- R1: After reset, all scratch, cause, trap-value and exception-PC registers read zero, the ISA register (0x301) reads parameter MISA_RST, the status register (0x300) reads parameter MSTATUS_RST, and xlen_err_o is 0.
- R2: A write to machine exception PC (0x341) or supervisor exception PC (0x141) always stores the written value with bit 0 cleared.
- R3: An exception-PC write clears bit 1 as well when ISA bit 2 (compressed) is 0, and keeps bit 1 when it is 1. The value of bit 2 in the cycle of the write is the one used.
- R4: Writes to 0x340, 0x342, 0x343, 0x140, 0x142 and 0x143 store the value unchanged, and reading the same address returns it.
- R5: Writes to the ISA register (0x301) and the status register (0x300) store the value unchanged.
- R6: xlen_o is the width field selected by priv_i. For 2'b11 (machine) it is ISA bits 63:62. For 2'b01 (supervisor) it is status bits 35:34. For 2'b00 (user) it is status bits 33:32. For the reserved encoding 2'b10 it is 2'b00.
- R7: rv32_mode_o is 1 exactly when xlen_o is 2'b01. The code 2'b10 means 64-bit and 2'b11 means 128-bit.
- R8: When xlen_o is 2'b00 at a rising edge, xlen_err_o becomes 1 from that edge on and stays 1 until reset.
- R9: has_amo_o is ISA bit 0 and has_rvc_o is ISA bit 2. has_muldiv_o is ISA bit 12. has_fp_o is ISA bit 5 OR ISA bit 3.
- R10: Reads of any other address return zero, and writes to such an address change no register.
- R11: Changing ISA bit 2 after an exception-PC write does not alter the stored exception PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_we_i | input | 1 | Write enable |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Combinational read data |
| xlen_o | output | 2 | Effective width code for the current privilege |
| rv32_mode_o | output | 1 | Effective width is 32-bit |
| xlen_err_o | output | 1 | Sticky flag: the selected width field was invalid |
| has_amo_o | output | 1 | Atomic extension present |
| has_rvc_o | output | 1 | Compressed extension present |
| has_muldiv_o | output | 1 | Multiply/divide extension present |
| has_fp_o | output | 1 | Single- or double-precision float present |

## Verification
The assertions assume that the address, write enable and data are stable around the clock edge. They also assume that after reset the selected width field holds a legal code until the bench chooses otherwise, so that the sticky error checks start from a clean flag. The stimulus changes inputs only on falling edges. Every ISA and status value it writes keeps the width fields legal. It drives the reserved privilege encoding only in the final scenario, which is the one that tests the error flag.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;
  localparam int XLEN = 64;
  localparam int AW   = 12;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    XL_BAD = 2'b00,
    XL_32  = 2'b01,
    XL_64  = 2'b10,
    XL_128 = 2'b11
  } xl_e;

  localparam logic [AW-1:0] A_MSTATUS = 12'h300;
  localparam logic [AW-1:0] A_MISA    = 12'h301;
  localparam logic [AW-1:0] A_MEPC    = 12'h341;
  localparam logic [AW-1:0] A_SEPC    = 12'h141;

  // plain registers: index 0..5 = mscratch, mcause, mtval, sscratch, scause, stval
  localparam int N_PLAIN = 6;
  localparam logic [N_PLAIN-1:0][AW-1:0] PLAIN_ADDR =
    {12'h143, 12'h142, 12'h140, 12'h343, 12'h342, 12'h340};

  localparam int N_EPC = 2;
  localparam logic [N_EPC-1:0][AW-1:0] EPC_ADDR = {A_SEPC, A_MEPC};

  // ISA register bit positions
  localparam int ISA_A = 0;
  localparam int ISA_C = 2;
  localparam int ISA_D = 3;
  localparam int ISA_F = 5;
  localparam int ISA_M = 12;
  // status register width fields (low bit of each pair)
  localparam int ST_SXL_LO = 34;
  localparam int ST_UXL_LO = 32;
endpackage

// File: rtl/trap_csr_epc_legal.sv
module trap_csr_epc_legal
  import trap_csr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         rvc_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] mask;

  always_comb begin
    mask    = '1;
    mask[0] = 1'b0;
    if (!rvc_i) mask[1] = 1'b0;
    q_o = d_i & mask;
  end
endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
  import trap_csr_pkg::*;
#(
  parameter int              W           = XLEN,
  parameter logic [W-1:0]    MISA_RST    = '0,
  parameter logic [W-1:0]    MSTATUS_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  misa_o,
  output logic [W-1:0]  mstatus_o
);
  logic [N_PLAIN-1:0][W-1:0] plain_q;
  logic [N_EPC-1:0][W-1:0]   epc_q;
  logic [W-1:0]              misa_q, mstatus_q, epc_wdata;
  logic [N_PLAIN-1:0]        plain_hit;
  logic [N_EPC-1:0]          epc_hit;
  logic                      hit_any;

  trap_csr_epc_legal #(.W(W)) u_legal (
    .rvc_i (misa_q[ISA_C]),
    .d_i   (wdata_i),
    .q_o   (epc_wdata)
  );

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain_dec
    assign plain_hit[i] = (addr_i == PLAIN_ADDR[i]);
  end
  for (genvar e = 0; e < N_EPC; e++) begin : g_epc_dec
    assign epc_hit[e] = (addr_i == EPC_ADDR[e]);
  end

  assign hit_any = (|plain_hit) | (|epc_hit) | (addr_i == A_MISA) | (addr_i == A_MSTATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plain_q   <= '0;
      epc_q     <= '0;
      misa_q    <= MISA_RST;
      mstatus_q <= MSTATUS_RST;
    end else if (we_i) begin
      for (int i = 0; i < N_PLAIN; i++)
        if (plain_hit[i]) plain_q[i] <= wdata_i;
      for (int e = 0; e < N_EPC; e++)
        if (epc_hit[e]) epc_q[e] <= epc_wdata;
      if (addr_i == A_MISA)    misa_q    <= wdata_i;
      if (addr_i == A_MSTATUS) mstatus_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_PLAIN; i++)
      if (plain_hit[i]) rdata_o = plain_q[i];
    for (int e = 0; e < N_EPC; e++)
      if (epc_hit[e]) rdata_o = epc_q[e];
    if (addr_i == A_MISA)    rdata_o = misa_q;
    if (addr_i == A_MSTATUS) rdata_o = mstatus_q;
  end

  assign misa_o    = misa_q;
  assign mstatus_o = mstatus_q;

  AST_EPC_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epc_q[0][0] == 1'b0) && (epc_q[1][0] == 1'b0)); // R2
  AST_EPC_NORVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_MEPC) && !misa_q[ISA_C]) |=> (epc_q[0][1:0] == 2'b00)); // R3
  AST_EPC_RVC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_SEPC) && misa_q[ISA_C]) |=> (epc_q[1][1] == $past(wdata_i[1]))); // R3
  AST_PLAIN_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && plain_hit[0]) |=> (plain_q[0] == $past(wdata_i))); // R4
  AST_UNMAPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit_any) |=> ($stable(plain_q) && $stable(epc_q) && $stable(misa_q) && $stable(mstatus_q))); // R10
  AST_EPC_NO_REWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (|epc_hit)) |=> $stable(epc_q)); // R11
endmodule

// File: rtl/trap_csr_arch.sv
module trap_csr_arch
  import trap_csr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   priv_i,
  input  logic [W-1:0] misa_i,
  input  logic [W-1:0] mstatus_i,
  output logic [1:0]   xlen_o,
  output logic         rv32_mode_o,
  output logic         xlen_err_o,
  output logic         has_amo_o,
  output logic         has_rvc_o,
  output logic         has_muldiv_o,
  output logic         has_fp_o
);
  localparam int MXL_LO = W - 2;

  logic [1:0] code;
  logic       err_q;

  always_comb begin
    unique case (priv_i)
      PRIV_M:  code = misa_i[MXL_LO+1:MXL_LO];
      PRIV_S:  code = mstatus_i[ST_SXL_LO+1:ST_SXL_LO];
      PRIV_U:  code = mstatus_i[ST_UXL_LO+1:ST_UXL_LO];
      default: code = XL_BAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            err_q <= 1'b0;
    else if (code == XL_BAD) err_q <= 1'b1;
  end

  assign xlen_o       = code;
  assign rv32_mode_o  = (code == XL_32);
  assign xlen_err_o   = err_q;
  assign has_amo_o    = misa_i[ISA_A];
  assign has_rvc_o    = misa_i[ISA_C];
  assign has_muldiv_o = misa_i[ISA_M];
  assign has_fp_o     = misa_i[ISA_F] | misa_i[ISA_D];

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R8
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xlen_o == XL_BAD) |=> xlen_err_o); // R8
  AST_RSV_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == PRIV_RSV) |-> (xlen_o == XL_BAD) && !rv32_mode_o); // R6
endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
  import trap_csr_pkg::*;
#(
  parameter logic [XLEN-1:0] MISA_RST    = 64'h8000_0000_0000_102D,
  parameter logic [XLEN-1:0] MSTATUS_RST = 64'h0000_000A_0000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      priv_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic            csr_we_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic [1:0]      xlen_o,
  output logic            rv32_mode_o,
  output logic            xlen_err_o,
  output logic            has_amo_o,
  output logic            has_rvc_o,
  output logic            has_muldiv_o,
  output logic            has_fp_o
);
  logic [XLEN-1:0] misa, mstatus;

  trap_csr_bank #(
    .W           (XLEN),
    .MISA_RST    (MISA_RST),
    .MSTATUS_RST (MSTATUS_RST)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (csr_addr_i),
    .we_i      (csr_we_i),
    .wdata_i   (csr_wdata_i),
    .rdata_o   (csr_rdata_o),
    .misa_o    (misa),
    .mstatus_o (mstatus)
  );

  trap_csr_arch #(.W(XLEN)) u_arch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .priv_i       (priv_i),
    .misa_i       (misa),
    .mstatus_i    (mstatus),
    .xlen_o       (xlen_o),
    .rv32_mode_o  (rv32_mode_o),
    .xlen_err_o   (xlen_err_o),
    .has_amo_o    (has_amo_o),
    .has_rvc_o    (has_rvc_o),
    .has_muldiv_o (has_muldiv_o),
    .has_fp_o     (has_fp_o)
  );

  AST_RV32_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rv32_mode_o |-> (xlen_o == 2'b01)); // R7
endmodule

// File: tb/sim_trap_csr_file.sv
module sim_trap_csr_file;
  localparam logic [63:0] MISA_RST    = 64'h8000_0000_0000_102D;
  localparam logic [63:0] MSTATUS_RST = 64'h0000_000A_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = 2'b11;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [1:0]  xlen;
  logic        rv32, xerr, amo, rvc, muldiv, fp;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trap_csr_file #(.MISA_RST(MISA_RST), .MSTATUS_RST(MSTATUS_RST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv),
    .csr_addr_i(addr), .csr_we_i(we), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .xlen_o(xlen), .rv32_mode_o(rv32), .xlen_err_o(xerr),
    .has_amo_o(amo), .has_rvc_o(rvc), .has_muldiv_o(muldiv), .has_fp_o(fp)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    logic [11:0] regs [8] = '{12'h340, 12'h342, 12'h343, 12'h140, 12'h142, 12'h143, 12'h341, 12'h141};
    foreach (regs[k]) begin
      rd(regs[k], v);
      chk("R1 reg zero", v, 64'h0);
    end
    rd(12'h301, v); chk("R1 misa reset", v, MISA_RST);
    rd(12'h300, v); chk("R1 mstatus reset", v, MSTATUS_RST);
    chk("R1 err reset", {63'h0, xerr}, 64'h0);
    chk("R6 machine width 64", {62'h0, xlen}, 64'h2);
    chk("R7 rv32 low", {63'h0, rv32}, 64'h0);
  endtask

  task automatic t_plain();
    logic [63:0] v;
    logic [11:0] regs [6] = '{12'h340, 12'h342, 12'h343, 12'h140, 12'h142, 12'h143};
    foreach (regs[k]) wr(regs[k], 64'hA5A5_0000_0000_0003 ^ (64'(k) << 8) ^ 64'(k));
    foreach (regs[k]) begin
      rd(regs[k], v);
      chk("R4 plain store", v, 64'hA5A5_0000_0000_0003 ^ (64'(k) << 8) ^ 64'(k));
    end
  endtask

  task automatic t_epc_rvc();
    logic [63:0] v;
    wr(12'h341, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h341, v); chk("R2 mepc bit0 rvc on", v, 64'hFFFF_FFFF_FFFF_FFFE);
    wr(12'h141, 64'h1234_0000_0000_0003);
    rd(12'h141, v); chk("R3 sepc keeps bit1 rvc on", v, 64'h1234_0000_0000_0002);
  endtask

  task automatic t_epc_norvc();
    logic [63:0] v;
    wr(12'h301, MISA_RST & ~64'h4);
    chk("R9 rvc flag off", {63'h0, rvc}, 64'h0);
    wr(12'h341, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h341, v); chk("R3 mepc rvc off", v, 64'hFFFF_FFFF_FFFF_FFFC);
    wr(12'h141, 64'h0000_0000_8000_0006);
    rd(12'h141, v); chk("R3 sepc rvc off", v, 64'h0000_0000_8000_0004);
    wr(12'h301, MISA_RST);
    rd(12'h341, v); chk("R11 mepc not rewritten", v, 64'hFFFF_FFFF_FFFF_FFFC);
    rd(12'h141, v); chk("R11 sepc not rewritten", v, 64'h0000_0000_8000_0004);
  endtask

  task automatic t_misa_mstatus();
    logic [63:0] v;
    wr(12'h300, 64'h0000_000A_0000_1888);
    rd(12'h300, v); chk("R5 mstatus store", v, 64'h0000_000A_0000_1888);
    wr(12'h301, 64'h8000_0000_0014_112D);
    rd(12'h301, v); chk("R5 misa store", v, 64'h8000_0000_0014_112D);
    wr(12'h301, MISA_RST);
  endtask

  task automatic t_width();
    wr(12'h301, 64'h4000_0000_0000_102D);
    wr(12'h300, 64'h0000_000D_0000_0000);
    @(negedge clk); priv = 2'b11; #1;
    chk("R6 machine MXL", {62'h0, xlen}, 64'h1);
    chk("R7 rv32 machine", {63'h0, rv32}, 64'h1);
    @(negedge clk); priv = 2'b01; #1;
    chk("R6 supervisor SXL", {62'h0, xlen}, 64'h3);
    chk("R7 rv32 off 128", {63'h0, rv32}, 64'h0);
    @(negedge clk); priv = 2'b00; #1;
    chk("R6 user UXL", {62'h0, xlen}, 64'h1);
    chk("R7 rv32 user", {63'h0, rv32}, 64'h1);
    @(negedge clk); priv = 2'b11;
    wr(12'h301, MISA_RST);
    wr(12'h300, MSTATUS_RST);
    #1 chk("R7 rv32 off 64", {63'h0, rv32}, 64'h0);
  endtask

  task automatic t_flags();
    wr(12'h301, 64'h8000_0000_0000_1001);
    #1 chk("R9 A+M flags", {60'h0, amo, rvc, muldiv, fp}, 64'b1010);
    wr(12'h301, 64'h8000_0000_0000_0008);
    #1 chk("R9 D only", {60'h0, amo, rvc, muldiv, fp}, 64'b0001);
    wr(12'h301, 64'h8000_0000_0000_0020);
    #1 chk("R9 F only", {60'h0, amo, rvc, muldiv, fp}, 64'b0001);
    wr(12'h301, MISA_RST);
    #1 chk("R9 reset set", {60'h0, amo, rvc, muldiv, fp}, 64'b1111);
  endtask

  task automatic t_unmapped();
    logic [63:0] v;
    wr(12'h340, 64'hDEAD_BEEF_0000_1111);
    wr(12'h344, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h041, 64'h5555_5555_5555_5555);
    rd(12'h344, v); chk("R10 unmapped reads zero", v, 64'h0);
    rd(12'h041, v); chk("R10 unmapped reads zero 2", v, 64'h0);
    rd(12'h340, v); chk("R10 mscratch untouched", v, 64'hDEAD_BEEF_0000_1111);
    rd(12'h341, v); chk("R10 mepc untouched", v, 64'hFFFF_FFFF_FFFF_FFFC);
    rd(12'h301, v); chk("R10 misa untouched", v, MISA_RST);
  endtask

  task automatic t_err();
    chk("R8 err clear before", {63'h0, xerr}, 64'h0);
    @(negedge clk); priv = 2'b10; #1;
    chk("R6 reserved priv code", {62'h0, xlen}, 64'h0);
    chk("R8 err not yet", {63'h0, xerr}, 64'h0);
    @(negedge clk); priv = 2'b11; #1;
    chk("R8 err set", {63'h0, xerr}, 64'h1);
    repeat (4) @(negedge clk);
    chk("R8 err sticky", {63'h0, xerr}, 64'h1);
    chk("R6 machine width after", {62'h0, xlen}, 64'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_epc_rvc();
    t_epc_norvc();
    t_misa_mstatus();
    t_width();
    t_flags();
    t_unmapped();
    t_err();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule